// File: doc/BRIEF.md
# Watchdog Basic Timer Counter

This block is an 8-bit free-running timer that also acts as a watchdog. A prescaler divides the CPU clock by one of four ratios, and each prescaler period advances the counter by one. When the counter rolls over from FFh to 00h while the watchdog is armed, the block raises a one-cycle reset request toward the chip reset logic.

Software controls the block through one byte-wide control register and can read the live counter value at any time. The register's all-zero reset value arms the watchdog and selects the slowest clock. Software keeps the system alive by writing a one to a self-clearing clear bit at regular intervals. A fixed four-bit pattern in the upper nibble disarms the watchdog, and the counter then simply wraps.

Top module: `wdt_basic_timer`

## Requirements
- R1: After reset, the control register reads 00h, the counter reads 00h, the reset request is low, and the watchdog is armed.
- R2: After reset, the counter advances once every 4096 CPU clocks, with its first increment on the 4096th rising edge.
- R3: Control bits [3:2] select the prescaler ratio: 00 gives 4096, 01 gives 1024, 10 gives 128 and 11 gives 16 CPU clocks per count.
- R4: A write with bit 1 set clears both the counter and the prescaler on that edge, so the next increment is a full period later. Bit 1 always reads 0.
- R5: A write that changes bits [3:2] restarts the prescaler from zero without changing the counter.
- R6: When the watchdog is armed and the counter wraps from FFh to 00h, the reset request goes high for exactly one clock, in the same cycle the counter first reads 00h.
- R7: The value 1010 in bits [7:4] disarms the watchdog, and every other value arms it. While disarmed, a wrap changes the counter to 00h and leaves the reset request low.
- R8: Clear writes made at intervals shorter than one full counter period keep the reset request low indefinitely.
- R9: Bits [7:2] and bit 0 read back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| cnt_value | output | 8 | Current counter value |
| rst_req | output | 1 | Registered one-cycle system reset request |

## Verification
The assertions assume that the write strobe and write data are stable around each rising clock edge and never unknown once reset is released. The bench meets this by changing inputs only on falling edges and by holding the strobe for a single cycle per write. The properties also assume that reset is released synchronously to a falling edge, so the prescaler phase after reset is known. The bench releases reset at a falling edge and counts rising edges from that point to predict every counter value and every reset-request cycle.

// File: rtl/wdt_basic_timer.sv
module wdt_basic_timer #(
  parameter int DIV_SEL0 = 4096,
  parameter int DIV_SEL1 = 1024,
  parameter int DIV_SEL2 = 128,
  parameter int DIV_SEL3 = 16,
  parameter logic [3:0] DISARM_KEY = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  output logic [7:0] cnt_value,
  output logic       rst_req
);
  localparam int PRE_W = $clog2(DIV_SEL0);

  logic [3:0]       key_q;
  logic [1:0]       sel_q;
  logic             spare_q;
  logic [PRE_W-1:0] pre_q;
  logic [7:0]       cnt_q;
  logic             req_q;
  logic [PRE_W-1:0] pre_last;

  always_comb begin
    case (sel_q)
      2'b00:   pre_last = PRE_W'(DIV_SEL0 - 1);
      2'b01:   pre_last = PRE_W'(DIV_SEL1 - 1);
      2'b10:   pre_last = PRE_W'(DIV_SEL2 - 1);
      default: pre_last = PRE_W'(DIV_SEL3 - 1);
    endcase
  end

  wire armed   = (key_q != DISARM_KEY);
  wire kick    = ctl_wr & ctl_wdata[1];
  wire sel_chg = ctl_wr & (ctl_wdata[3:2] != sel_q);
  wire tick    = (pre_q == pre_last) & ~sel_chg & ~kick;
  wire wrap    = tick & (cnt_q == 8'hFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= '0;
      sel_q   <= '0;
      spare_q <= 1'b0;
    end else if (ctl_wr) begin
      key_q   <= ctl_wdata[7:4];
      sel_q   <= ctl_wdata[3:2];
      spare_q <= ctl_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pre_q <= '0;
    else if (kick || sel_chg || pre_q == pre_last)
      pre_q <= '0;
    else
      pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (kick)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= cnt_q + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      req_q <= 1'b0;
    else
      req_q <= wrap & armed;
  end

  assign ctl_rdata = {key_q, sel_q, 1'b0, spare_q};
  assign cnt_value = cnt_q;
  assign rst_req   = req_q;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R6
  AST_REQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt_value == 8'h00 && $past(cnt_value) == 8'hFF)); // R6
  AST_REQ_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(ctl_rdata[7:4]) != DISARM_KEY)); // R7
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[1]) |=> (cnt_value == 8'h00 && !rst_req)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_value) |-> (cnt_value == $past(cnt_value) + 8'd1 || cnt_value == 8'h00)); // R2
  AST_SEL_HOLDS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_wdata[1] && ctl_wdata[3:2] != ctl_rdata[3:2]) |=> $stable(cnt_value)); // R5
endmodule

// File: tb/wdt_basic_timer_tb.sv
module wdt_basic_timer_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic [7:0] cnt_value;
  logic       rst_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  wdt_basic_timer u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .cnt_value(cnt_value), .rst_req(rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG_CYCLES) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", cycles, WATCHDOG_CYCLES);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [7:0] v);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = v;
    @(posedge clk);
    @(negedge clk);
    ctl_wr = 1'b0;
    ctl_wdata = 8'h00;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_and_default;
    check("R1 ctl_rdata", ctl_rdata, 8'h00);
    check("R1 cnt_value", cnt_value, 8'h00);
    check("R1 rst_req", rst_req, 1'b0);
    edges(4095);
    check("R2 cnt before 4096 edges", cnt_value, 8'h00);
    edges(1);
    check("R2 cnt after 4096 edges", cnt_value, 8'h01);
  endtask

  task automatic t_dividers;
    write_ctl(8'h06);
    edges(3 * 1024 - 1);
    check("R3 div1024 cnt", cnt_value, 8'h02);
    edges(1);
    check("R3 div1024 cnt", cnt_value, 8'h03);
    write_ctl(8'h0A);
    edges(5 * 128 - 1);
    check("R3 div128 cnt", cnt_value, 8'h04);
    edges(1);
    check("R3 div128 cnt", cnt_value, 8'h05);
    write_ctl(8'h0E);
    edges(16 * 7);
    check("R3 div16 cnt", cnt_value, 8'h07);
  endtask

  task automatic t_clear_bit;
    write_ctl(8'h0E);
    edges(16 * 9 + 10);
    check("R4 cnt before clear", cnt_value, 8'h09);
    write_ctl(8'h0E);
    check("R4 cnt cleared", cnt_value, 8'h00);
    check("R4 bit1 reads 0", ctl_rdata[1], 1'b0);
    edges(15);
    check("R4 full period after clear", cnt_value, 8'h00);
    edges(1);
    check("R4 first step after clear", cnt_value, 8'h01);
  endtask

  task automatic t_sel_restart;
    write_ctl(8'h06);
    edges(1000);
    write_ctl(8'h0C);
    check("R5 cnt kept on select change", cnt_value, 8'h00);
    edges(15);
    check("R5 restart before period", cnt_value, 8'h00);
    edges(1);
    check("R5 restart after period", cnt_value, 8'h01);
  endtask

  task automatic t_wrap_armed;
    write_ctl(8'hBE);
    check("R7 key 1011 arms readback", ctl_rdata, 8'hBC);
    edges(4095);
    check("R6 cnt FF before wrap", cnt_value, 8'hFF);
    check("R6 no req before wrap", rst_req, 1'b0);
    edges(1);
    check("R6 cnt 00 at wrap", cnt_value, 8'h00);
    check("R6 req at wrap", rst_req, 1'b1);
    edges(1);
    check("R6 req one cycle", rst_req, 1'b0);
  endtask

  task automatic t_wrap_disarmed;
    int seen;
    write_ctl(8'hAE);
    seen = 0;
    repeat (4096) begin
      @(posedge clk);
      @(negedge clk);
      if (rst_req) seen++;
    end
    check("R7 cnt wrapped when disarmed", cnt_value, 8'h00);
    check("R7 no req when disarmed", seen, 0);
  endtask

  task automatic t_kick;
    int seen;
    write_ctl(8'h0E);
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      repeat (3000) begin
        @(posedge clk);
        @(negedge clk);
        if (rst_req) seen++;
      end
      write_ctl(8'h0E);
    end
    check("R8 periodic clear holds off req", seen, 0);
  endtask

  task automatic t_readback;
    write_ctl(8'hFF);
    check("R9 readback FF", ctl_rdata, 8'hFD);
    write_ctl(8'h51);
    check("R9 readback 51", ctl_rdata, 8'h51);
    write_ctl(8'h00);
    check("R9 readback 00", ctl_rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_and_default();
    t_dividers();
    t_clear_bit();
    t_sel_restart();
    t_wrap_armed();
    t_wrap_disarmed();
    t_kick();
    t_readback();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule